// File: doc/BRIEF.md
# Critical-Load Last-Value Predictor

The block guesses the result of a load that misses in the data cache, so that instructions depending on it can start before memory answers. It keeps a direct-mapped table indexed by the load's instruction address. Each entry holds an address tag, the value the load returned most recently, and a 2-bit confidence counter. Loads that hit in the data cache never reach the table. For a critical load the block returns the stored value one cycle later, together with a flag that says whether the confidence is high enough for dependents to use it.

When the real value arrives, the pipeline presents it on the verify port along with the load's instruction address and its identifier. The block compares the real value with the stored one, writes the real value back and adjusts the confidence. If a usable prediction turns out to be wrong, it raises a squash request carrying the load identifier one cycle later. The logic that squashes and reissues the dependent instructions sits outside the block.

Top module: `critload_top`

## Requirements
- R1: One cycle after a lookup with `lk_valid`=1 and `lk_miss`=1, `pred_valid` is 1 if the entry at the load's index is occupied and its tag matches, and `pred_value` is the stored value. Otherwise `pred_valid` is 0.
- R2: A lookup with `lk_miss`=0 (a data cache hit) yields `pred_valid`=0 in the following cycle.
- R3: `pred_usable` is 1 exactly when `pred_valid` is 1 and the entry's confidence counter is 2 or 3.
- R4: A verify whose tag matches writes the actual value into the entry. A matching value raises the counter by one, stopping at 3. A differing value clears the counter to 0.
- R5: A verify whose tag misses, or whose entry is empty, fills the entry with the new tag, the actual value and confidence 0. It raises no squash, even if the previous occupant was at usable confidence.
- R6: One cycle after a verify, `sq_valid` is 1 and `sq_id` equals the verify's `vf_id` exactly when the tag matched, the confidence was 2 or more, and the actual value differed from the stored value. A mismatch at confidence 0 or 1 raises no squash.
- R7: The index is address bits [11:2] with the default parameters, and the tag is bits [31:12]. Two loads sharing an index evict each other, and loads at different indices do not interfere.
- R8: Reset empties every entry and drives `pred_valid`, `pred_usable` and `sq_valid` to 0.
- R9: A lookup and a verify to the same entry in the same cycle return the contents from before the update. The update becomes visible to the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_miss | input | 1 | The load missed in the data cache |
| lk_pc | input | PC_W | Instruction address of the load being looked up |
| pred_valid | output | 1 | A prediction is present |
| pred_usable | output | 1 | The prediction has enough confidence to be consumed |
| pred_value | output | VALUE_W | Predicted load value |
| vf_valid | input | 1 | Verify request with the real value |
| vf_pc | input | PC_W | Instruction address of the verified load |
| vf_id | input | ID_W | Identifier of the verified load |
| vf_value | input | VALUE_W | Actual value returned by memory |
| sq_valid | output | 1 | Squash request for the dependents of a load |
| sq_id | output | ID_W | Identifier of the load whose dependents are reissued |

## Verification
The hardest case to reach is a squash: an entry has to be built up to usable confidence through repeated verifies with the same value before a differing value can trigger one. The vectors do this twice. The second time the counter is first driven past its ceiling, so a counter that wrapped instead of saturating would lose the squash. The stimulus also covers eviction by an aliasing address while the previous occupant is at usable confidence, which must not squash, and a mismatch at confidence 1, which must not squash either. Directed steps then issue a lookup and a verify to the same entry in one cycle, and assert reset a second time on a filled table to show that it empties.

// File: rtl/critload_pkg.sv
package critload_pkg;

    typedef logic [1:0] conf_t;

    localparam conf_t CONF_MAX = 2'd3;
    localparam conf_t CONF_USE = 2'd2;

    function automatic conf_t conf_step(conf_t cur, logic same);
        conf_t nxt;
        if (!same)
            nxt = '0;
        else if (cur == CONF_MAX)
            nxt = cur;
        else
            nxt = cur + 2'd1;
        return nxt;
    endfunction

    function automatic logic conf_ok(conf_t cur);
        return cur >= CONF_USE;
    endfunction

endpackage

// File: rtl/critload_table.sv
module critload_table
    import critload_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int TAG_W   = 20,
    parameter int VALUE_W = 32,
    parameter int NRD     = 2,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]       rd_idx,
    output logic [NRD-1:0]                  rd_used,
    output logic [NRD-1:0][TAG_W-1:0]       rd_tag,
    output logic [NRD-1:0][VALUE_W-1:0]     rd_value,
    output conf_t [NRD-1:0]                 rd_conf,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [TAG_W-1:0]                wr_tag,
    input  logic [VALUE_W-1:0]              wr_value,
    input  conf_t                           wr_conf
);

    logic [DEPTH-1:0]   used_q;
    logic [TAG_W-1:0]   tag_q   [DEPTH];
    logic [VALUE_W-1:0] value_q [DEPTH];
    conf_t              conf_q  [DEPTH];

    // occupancy is the only state that reset clears
    always_ff @(posedge clk) begin
        if (!rst_n)
            used_q <= '0;
        else if (wr_en)
            used_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]   <= wr_tag;
            value_q[wr_idx] <= wr_value;
            conf_q[wr_idx]  <= wr_conf;
        end
    end

    // asynchronous read ports: they see the contents from before this cycle's write
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_used[p]  = used_q[rd_idx[p]];
        assign rd_tag[p]   = tag_q[rd_idx[p]];
        assign rd_value[p] = value_q[rd_idx[p]];
        assign rd_conf[p]  = conf_q[rd_idx[p]];
    end

    // R8
    table_reset_chk: assert property (@(posedge clk)
        !rst_n |=> used_q == '0);

endmodule

// File: rtl/critload_judge.sv
module critload_judge
    import critload_pkg::*;
#(
    parameter int TAG_W   = 20,
    parameter int VALUE_W = 32
) (
    input  logic               hit,
    input  logic [TAG_W-1:0]   new_tag,
    input  logic [VALUE_W-1:0] new_value,
    input  logic [VALUE_W-1:0] old_value,
    input  conf_t              old_conf,
    output logic [TAG_W-1:0]   out_tag,
    output logic [VALUE_W-1:0] out_value,
    output conf_t              out_conf,
    output logic               wrong
);

    logic same;

    always_comb begin
        same      = (new_value == old_value);
        out_tag   = new_tag;
        out_value = new_value;
        if (hit) begin
            out_conf = conf_step(old_conf, same);
            wrong    = conf_ok(old_conf) && !same;
        end else begin
            out_conf = '0;
            wrong    = 1'b0;
        end
    end

endmodule

// File: rtl/critload_top.sv
module critload_top
    import critload_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int VALUE_W = 32,
    parameter int DEPTH   = 1024,
    parameter int ID_W    = 6,
    parameter int PC_LSB  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic               lk_miss,
    input  logic [PC_W-1:0]    lk_pc,
    output logic               pred_valid,
    output logic               pred_usable,
    output logic [VALUE_W-1:0] pred_value,
    input  logic               vf_valid,
    input  logic [PC_W-1:0]    vf_pc,
    input  logic [ID_W-1:0]    vf_id,
    input  logic [VALUE_W-1:0] vf_value,
    output logic               sq_valid,
    output logic [ID_W-1:0]    sq_id
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int TAG_W = PC_W - IDX_W - PC_LSB;
    localparam int NRD   = 2;
    localparam int RP_LK = 0;
    localparam int RP_VF = 1;

    typedef struct packed {
        logic               pv;
        logic               pu;
        logic [VALUE_W-1:0] pval;
        logic               sv;
        logic [ID_W-1:0]    sid;
    } outs_t;

    outs_t o_d, o_q;

    logic [IDX_W-1:0] lk_idx, vf_idx;
    logic [TAG_W-1:0] lk_tag, vf_tag;
    logic             unused_pc_low;

    assign lk_idx        = lk_pc[PC_LSB +: IDX_W];
    assign vf_idx        = vf_pc[PC_LSB +: IDX_W];
    assign lk_tag        = lk_pc[PC_W-1 -: TAG_W];
    assign vf_tag        = vf_pc[PC_W-1 -: TAG_W];
    assign unused_pc_low = ^{lk_pc[PC_LSB-1:0], vf_pc[PC_LSB-1:0]};

    logic [NRD-1:0][IDX_W-1:0]   rd_idx;
    logic [NRD-1:0]              rd_used;
    logic [NRD-1:0][TAG_W-1:0]   rd_tag;
    logic [NRD-1:0][VALUE_W-1:0] rd_value;
    conf_t [NRD-1:0]             rd_conf;

    assign rd_idx[RP_LK] = lk_idx;
    assign rd_idx[RP_VF] = vf_idx;

    logic [TAG_W-1:0]   wr_tag;
    logic [VALUE_W-1:0] wr_value;
    conf_t              wr_conf;
    logic               wrong;
    logic               lk_hit, vf_hit;

    assign lk_hit = rd_used[RP_LK] && (rd_tag[RP_LK] == lk_tag);
    assign vf_hit = rd_used[RP_VF] && (rd_tag[RP_VF] == vf_tag);

    critload_table #(
        .DEPTH   (DEPTH),
        .TAG_W   (TAG_W),
        .VALUE_W (VALUE_W),
        .NRD     (NRD)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_used  (rd_used),
        .rd_tag   (rd_tag),
        .rd_value (rd_value),
        .rd_conf  (rd_conf),
        .wr_en    (vf_valid),
        .wr_idx   (vf_idx),
        .wr_tag   (wr_tag),
        .wr_value (wr_value),
        .wr_conf  (wr_conf)
    );

    critload_judge #(
        .TAG_W   (TAG_W),
        .VALUE_W (VALUE_W)
    ) u_judge (
        .hit       (vf_hit),
        .new_tag   (vf_tag),
        .new_value (vf_value),
        .old_value (rd_value[RP_VF]),
        .old_conf  (rd_conf[RP_VF]),
        .out_tag   (wr_tag),
        .out_value (wr_value),
        .out_conf  (wr_conf),
        .wrong     (wrong)
    );

    always_comb begin
        o_d      = o_q;
        o_d.pv   = lk_valid && lk_miss && lk_hit;
        o_d.pu   = o_d.pv && conf_ok(rd_conf[RP_LK]);
        o_d.pval = o_d.pv ? rd_value[RP_LK] : '0;
        o_d.sv   = vf_valid && wrong;
        o_d.sid  = vf_valid ? vf_id : o_q.sid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            o_q <= '0;
        else
            o_q <= o_d;
    end

    assign pred_valid  = o_q.pv;
    assign pred_usable = o_q.pu;
    assign pred_value  = o_q.pval;
    assign sq_valid    = o_q.sv;
    assign sq_id       = o_q.sid;

    // R2
    pred_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> $past(lk_valid && lk_miss));

    // R3
    usable_needs_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_usable |-> pred_valid);

    // R6
    squash_needs_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> $past(vf_valid));

    // R6
    squash_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> sq_id == $past(vf_id));

    // R5
    fill_no_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_valid && !vf_hit) |=> !sq_valid);

endmodule

// File: tb/critload_top_test.sv
module critload_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_miss;
    logic [31:0] lk_pc;
    logic        pred_valid, pred_usable;
    logic [31:0] pred_value;
    logic        vf_valid;
    logic [31:0] vf_pc;
    logic [5:0]  vf_id;
    logic [31:0] vf_value;
    logic        sq_valid;
    logic [5:0]  sq_id;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    critload_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_valid    (lk_valid),
        .lk_miss     (lk_miss),
        .lk_pc       (lk_pc),
        .pred_valid  (pred_valid),
        .pred_usable (pred_usable),
        .pred_value  (pred_value),
        .vf_valid    (vf_valid),
        .vf_pc       (vf_pc),
        .vf_id       (vf_id),
        .vf_value    (vf_value),
        .sq_valid    (sq_valid),
        .sq_id       (sq_id)
    );

    // op: 0 lookup of a cache miss, 1 lookup of a cache hit, 2 verify
    // lookup: ea = pred_valid, eb = pred_usable, ev = pred_value (when ea)
    // verify: ea = sq_valid, ev = sq_id (when ea)
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] pc;
        logic [5:0]  id;
        logic [31:0] val;
        logic        ea;
        logic        eb;
        logic [31:0] ev;
    } vec_t;

    localparam logic [31:0] PA = 32'h0000_1000; // index 0, tag 1
    localparam logic [31:0] PB = 32'h0000_2000; // index 0, tag 2
    localparam logic [31:0] PC = 32'h0000_1004; // index 1, tag 1
    localparam logic [31:0] PD = 32'h0000_0FFC; // index 1023, tag 0
    localparam int NV = 31;

    localparam vec_t VECS [NV] = '{
        '{2'd0, PA, 6'd0,  32'h0,  1'b0, 1'b0, 32'h0},  // 0  empty table
        '{2'd2, PA, 6'd1,  32'h11, 1'b0, 1'b0, 32'h0},  // 1  fill, conf 0
        '{2'd0, PA, 6'd0,  32'h0,  1'b1, 1'b0, 32'h11}, // 2
        '{2'd2, PA, 6'd2,  32'h11, 1'b0, 1'b0, 32'h0},  // 3  conf 1
        '{2'd0, PA, 6'd0,  32'h0,  1'b1, 1'b0, 32'h11}, // 4
        '{2'd2, PA, 6'd3,  32'h11, 1'b0, 1'b0, 32'h0},  // 5  conf 2
        '{2'd0, PA, 6'd0,  32'h0,  1'b1, 1'b1, 32'h11}, // 6  usable
        '{2'd1, PA, 6'd0,  32'h0,  1'b0, 1'b0, 32'h0},  // 7  cache hit
        '{2'd2, PA, 6'd4,  32'h22, 1'b1, 1'b0, 32'h4},  // 8  squash
        '{2'd0, PA, 6'd0,  32'h0,  1'b1, 1'b0, 32'h22}, // 9  conf 0, new value
        '{2'd2, PA, 6'd8,  32'h22, 1'b0, 1'b0, 32'h0},  // 10 conf 1
        '{2'd2, PA, 6'd8,  32'h22, 1'b0, 1'b0, 32'h0},  // 11 conf 2
        '{2'd2, PA, 6'd8,  32'h22, 1'b0, 1'b0, 32'h0},  // 12 conf 3
        '{2'd2, PA, 6'd8,  32'h22, 1'b0, 1'b0, 32'h0},  // 13 stays 3
        '{2'd0, PA, 6'd0,  32'h0,  1'b1, 1'b1, 32'h22}, // 14
        '{2'd2, PA, 6'd9,  32'h23, 1'b1, 1'b0, 32'h9},  // 15 squash after saturation
        '{2'd0, PA, 6'd0,  32'h0,  1'b1, 1'b0, 32'h23}, // 16
        '{2'd2, PA, 6'd9,  32'h23, 1'b0, 1'b0, 32'h0},  // 17 conf 1
        '{2'd2, PA, 6'd9,  32'h23, 1'b0, 1'b0, 32'h0},  // 18 conf 2
        '{2'd0, PA, 6'd0,  32'h0,  1'b1, 1'b1, 32'h23}, // 19
        '{2'd2, PB, 6'd5,  32'h33, 1'b0, 1'b0, 32'h0},  // 20 alias evicts, no squash
        '{2'd0, PA, 6'd0,  32'h0,  1'b0, 1'b0, 32'h0},  // 21 evicted
        '{2'd0, PB, 6'd0,  32'h0,  1'b1, 1'b0, 32'h33}, // 22
        '{2'd2, PC, 6'd6,  32'h44, 1'b0, 1'b0, 32'h0},  // 23 other index
        '{2'd0, PC, 6'd0,  32'h0,  1'b1, 1'b0, 32'h44}, // 24
        '{2'd0, PB, 6'd0,  32'h0,  1'b1, 1'b0, 32'h33}, // 25 untouched
        '{2'd2, PC, 6'd6,  32'h44, 1'b0, 1'b0, 32'h0},  // 26 conf 1
        '{2'd2, PC, 6'd10, 32'h55, 1'b0, 1'b0, 32'h0},  // 27 low-conf mismatch
        '{2'd0, PC, 6'd0,  32'h0,  1'b1, 1'b0, 32'h55}, // 28
        '{2'd2, PD, 6'd7,  32'h77, 1'b0, 1'b0, 32'h0},  // 29 top index, tag 0
        '{2'd0, PD, 6'd0,  32'h0,  1'b1, 1'b0, 32'h77}  // 30
    };

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 1'b0; lk_miss = 1'b0; lk_pc = '0;
        vf_valid = 1'b0; vf_pc = '0; vf_id = '0; vf_value = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8", "pred_valid after reset", {31'b0, pred_valid}, 32'h0);
        check("R8", "pred_usable after reset", {31'b0, pred_usable}, 32'h0);
        check("R8", "sq_valid after reset", {31'b0, sq_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.op == 2'd2) begin
                vf_valid = 1'b1; vf_pc = v.pc; vf_id = v.id; vf_value = v.val;
            end else begin
                lk_valid = 1'b1; lk_miss = (v.op == 2'd0); lk_pc = v.pc;
            end
            @(negedge clk);
            idle();
            if (v.op == 2'd2) begin
                // R4 R5 R6
                check("R6", $sformatf("vec %0d sq_valid", i), {31'b0, sq_valid}, {31'b0, v.ea});
                if (v.ea)
                    check("R6", $sformatf("vec %0d sq_id", i), {26'b0, sq_id}, v.ev);
            end else begin
                // R1 R2 R3 R7
                check(v.op == 2'd1 ? "R2" : "R1", $sformatf("vec %0d pred_valid", i),
                      {31'b0, pred_valid}, {31'b0, v.ea});
                check("R3", $sformatf("vec %0d pred_usable", i), {31'b0, pred_usable}, {31'b0, v.eb});
                if (v.ea)
                    check("R4", $sformatf("vec %0d pred_value", i), pred_value, v.ev);
            end
        end

        // R9: same-cycle lookup and verify to PB (conf 0, value 33)
        lk_valid = 1'b1; lk_miss = 1'b1; lk_pc = PB;
        vf_valid = 1'b1; vf_pc = PB; vf_id = 6'd12; vf_value = 32'h66;
        @(negedge clk);
        idle();
        check("R9", "same-cycle pred_valid", {31'b0, pred_valid}, 32'h1);
        check("R9", "same-cycle old value", pred_value, 32'h33);
        check("R9", "same-cycle sq_valid", {31'b0, sq_valid}, 32'h0);
        lk_valid = 1'b1; lk_miss = 1'b1; lk_pc = PB;
        @(negedge clk);
        idle();
        check("R9", "update visible next", pred_value, 32'h66);

        // R8: reset empties a filled table
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        lk_valid = 1'b1; lk_miss = 1'b1; lk_pc = PD;
        @(negedge clk);
        idle();
        check("R8", "entry cleared by reset", {31'b0, pred_valid}, 32'h0);
        lk_valid = 1'b1; lk_miss = 1'b1; lk_pc = PB;
        @(negedge clk);
        idle();
        check("R8", "aliased entry cleared", {31'b0, pred_valid}, 32'h0);

        @(negedge clk);
        finish_run();
    end

endmodule